// File: doc/BRIEF.md
# Limit Switch Stop Controller

This block watches the two end-of-travel switches of one motion axis and tells the pulse generator when it has to stop. One switch guards travel in the plus direction and the other guards travel in the minus direction. Both raw switch pins pass through multi-flop synchronizers. A configuration bit can exchange the two pins, and another sets whether the switches are active high or active low. This yields a per-direction limit status that software may read at any moment.

A stop is raised only when a move is in progress and the limit on the side of travel is enabled and active. A move that heads away from an active limit is allowed. The stop request is a single-cycle strobe on one of two outputs, for a decelerating stop or an immediate stop, as the configuration selects. Each limit-caused stop also sets a sticky per-direction error flag. The flag holds until a clear bit is written for that direction.

Top module: `limit_stop_ctrl`

## Requirements
- R1: `lim_status` reflects a change on the raw pins after exactly SYNC_STAGES (default 2) rising clock edges. It is shown whatever the values of `busy` and `cfg_en`, with bit 0 for the plus direction and bit 1 for the minus direction.
- R2: With `cfg_act_high`=1 a pin at 1 counts as active. With `cfg_act_high`=0 a pin at 0 counts as active.
- R3: With `cfg_swap`=1 the plus pin `pin_plus` feeds the minus direction and `pin_minus` feeds the plus direction. With `cfg_swap`=0 each pin feeds its own direction.
- R4: A direction whose `cfg_en` bit is 0 (bit 0 plus, bit 1 minus) never causes a stop or sets its error flag, though its status is still shown.
- R5: A stop is raised only for the direction of travel: `dir_minus`=0 for plus travel checks only the plus limit, and `dir_minus`=1 checks only the minus limit.
- R6: `cfg_decel`=1 routes a limit stop to `stop_decel`, and `cfg_decel`=0 routes it to `stop_now`. The two are never high together.
- R7: A stop is a one-cycle strobe. It appears one clock edge after the condition "`busy` high and the travel-side limit enabled and active" starts to hold. That happens either because a move starts against an active limit, or because the limit becomes active during a move. It does not repeat while the condition persists.
- R8: With `busy` low no stop is raised, whatever the limits.
- R9: On the edge that raises a stop, `lim_err` bit 0 (plus) or bit 1 (minus) is set for the direction of travel. It stays set until the matching `err_clr` bit is high at a clock edge. A set on the same edge wins over a clear.
- R10: While `rst_n` is low, `stop_decel`, `stop_now` and `lim_err` are 0, and with `cfg_act_high`=1 `lim_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_plus | input | 1 | Raw plus-direction limit switch pin |
| pin_minus | input | 1 | Raw minus-direction limit switch pin |
| cfg_en | input | 2 | Limit enable, bit 0 plus, bit 1 minus |
| cfg_act_high | input | 1 | 1: switches active high, 0: active low |
| cfg_decel | input | 1 | 1: decelerating stop, 0: immediate stop |
| cfg_swap | input | 1 | Exchange plus and minus pins |
| busy | input | 1 | A move is in progress |
| dir_minus | input | 1 | Direction of travel, 0 plus, 1 minus |
| err_clr | input | 2 | Clear the error flag, bit 0 plus, bit 1 minus |
| stop_decel | output | 1 | One-cycle decelerating stop request |
| stop_now | output | 1 | One-cycle immediate stop request |
| lim_status | output | 2 | Synchronized limit status, bit 0 plus, bit 1 minus |
| lim_err | output | 2 | Sticky limit error flags, bit 0 plus, bit 1 minus |

## Verification
A pin change reaches `lim_status` after two edges and a stop strobe after three. A change on `busy` or `dir_minus` gives a strobe, together with its error flag, after one edge. The bench drives every input just after a falling edge. It then counts falling edges so that each sample is taken half a period after the edge at which the result is due. The sample after that edge checks that the strobe has dropped again. Each table vector lets the pins settle for three edges with no move before it checks the status, and only then starts the move.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int NDIR      = 2;
  localparam int IDX_PLUS  = 0;
  localparam int IDX_MINUS = 1;

  typedef logic [NDIR-1:0] dir_vec_t;

  // Polarity first, then optional exchange of the two directions.
  function automatic dir_vec_t orient(dir_vec_t pins, logic act_high, logic swap);
    dir_vec_t lvl;
    lvl = act_high ? pins : ~pins;
    return swap ? {lvl[IDX_PLUS], lvl[IDX_MINUS]} : lvl;
  endfunction

  // Index of the limit that guards the current direction of travel.
  function automatic int unsigned travel_idx(logic dir_minus);
    return dir_minus ? IDX_MINUS : IDX_PLUS;
  endfunction
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lsc_eval.sv
module lsc_eval
  import lsc_pkg::*;
(
  input  dir_vec_t sync_pins,
  input  dir_vec_t en,
  input  logic     act_high,
  input  logic     swap,
  output dir_vec_t status,
  output dir_vec_t active
);
  always_comb begin
    status = orient(sync_pins, act_high, swap);
    active = status & en;
  end
endmodule

// File: rtl/lsc_stopgen.sv
module lsc_stopgen
  import lsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dir_vec_t active,
  input  logic     busy,
  input  logic     dir_minus,
  input  logic     decel,
  input  dir_vec_t err_clr,
  output logic     hit,
  output logic     hit_rise,
  output logic     stop_decel,
  output logic     stop_now,
  output dir_vec_t err
);
  logic hit_q;

  assign hit      = busy & active[travel_idx(dir_minus)];
  assign hit_rise = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q      <= 1'b0;
      stop_decel <= 1'b0;
      stop_now   <= 1'b0;
    end else begin
      hit_q      <= hit;
      stop_decel <= hit_rise & decel;
      stop_now   <= hit_rise & ~decel;
    end
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_err
    logic set_d;
    assign set_d = hit_rise && (travel_idx(dir_minus) == d);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err[d] <= 1'b0;
      else        err[d] <= set_d | (err[d] & ~err_clr[d]);
    end
  end
endmodule

// File: rtl/limit_stop_ctrl.sv
module limit_stop_ctrl
  import lsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_plus,
  input  logic       pin_minus,
  input  logic [1:0] cfg_en,
  input  logic       cfg_act_high,
  input  logic       cfg_decel,
  input  logic       cfg_swap,
  input  logic       busy,
  input  logic       dir_minus,
  input  logic [1:0] err_clr,
  output logic       stop_decel,
  output logic       stop_now,
  output logic [1:0] lim_status,
  output logic [1:0] lim_err
);
  dir_vec_t raw_pins_w;
  dir_vec_t sync_pins_w;
  dir_vec_t lim_active_w;
  logic     hit_w;
  logic     hit_rise_w;

  always_comb begin
    raw_pins_w            = '0;
    raw_pins_w[IDX_PLUS]  = pin_plus;
    raw_pins_w[IDX_MINUS] = pin_minus;
  end

  lsc_sync #(.WIDTH(NDIR), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_pins_w),
    .q     (sync_pins_w)
  );

  lsc_eval u_eval (
    .sync_pins (sync_pins_w),
    .en        (cfg_en),
    .act_high  (cfg_act_high),
    .swap      (cfg_swap),
    .status    (lim_status),
    .active    (lim_active_w)
  );

  lsc_stopgen u_stop (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (lim_active_w),
    .busy       (busy),
    .dir_minus  (dir_minus),
    .decel      (cfg_decel),
    .err_clr    (err_clr),
    .hit        (hit_w),
    .hit_rise   (hit_rise_w),
    .stop_decel (stop_decel),
    .stop_now   (stop_now),
    .err        (lim_err)
  );
endmodule

// File: rtl/lsc_chk.sv
module lsc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       dir_minus,
  input logic [1:0] err_clr,
  input logic [1:0] active,
  input logic       stop_decel,
  input logic       stop_now,
  input logic [1:0] lim_err
);
  logic stop_any;
  assign stop_any = stop_decel | stop_now;

  AST_STOP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_decel && stop_now)); // R6

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_any |=> !stop_any); // R7

  AST_STOP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_any |-> $past(busy)); // R8

  AST_PLUS_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_any && !$past(dir_minus)) |-> ($past(active[0]) && lim_err[0])); // R5

  AST_MINUS_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_any && $past(dir_minus)) |-> ($past(active[1]) && lim_err[1])); // R5

  AST_PLUS_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_err[0] && !err_clr[0]) |=> lim_err[0]); // R9

  AST_MINUS_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_err[1] && !err_clr[1]) |=> lim_err[1]); // R9
endmodule

bind limit_stop_ctrl lsc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .dir_minus  (dir_minus),
  .err_clr    (err_clr),
  .active     (lim_active_w),
  .stop_decel (stop_decel),
  .stop_now   (stop_now),
  .lim_err    (lim_err)
);

// File: tb/limit_stop_ctrl_tb.sv
module limit_stop_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_plus = 1'b0, pin_minus = 1'b0;
  logic [1:0] cfg_en = 2'b11;
  logic       cfg_act_high = 1'b1, cfg_decel = 1'b1, cfg_swap = 1'b0;
  logic       busy = 1'b0, dir_minus = 1'b0;
  logic [1:0] err_clr = 2'b00;
  logic       stop_decel, stop_now;
  logic [1:0] lim_status, lim_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_stop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_plus(pin_plus), .pin_minus(pin_minus),
    .cfg_en(cfg_en), .cfg_act_high(cfg_act_high), .cfg_decel(cfg_decel),
    .cfg_swap(cfg_swap), .busy(busy), .dir_minus(dir_minus), .err_clr(err_clr),
    .stop_decel(stop_decel), .stop_now(stop_now), .lim_status(lim_status),
    .lim_err(lim_err)
  );

  // {pin_minus,pin_plus, en[1:0], act_high, decel, swap, dir_minus,
  //  exp_status[1:0], exp_stop_decel, exp_stop_now, exp_err[1:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b01_11_1_1_0_0_01_1_0_01,
    14'b01_11_1_0_0_1_01_0_0_00,
    14'b10_11_1_0_0_1_10_0_1_10,
    14'b01_11_1_0_1_1_10_0_1_10,
    14'b01_11_1_1_1_0_10_0_0_00,
    14'b10_11_0_1_0_0_01_1_0_01,
    14'b11_11_0_1_0_1_00_0_0_00,
    14'b01_10_1_1_0_0_01_0_0_00,
    14'b10_01_1_0_0_1_10_0_0_00,
    14'b11_11_1_0_0_1_11_0_1_10
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    // R10 reset state
    chk("R10 stops", {6'b0, stop_decel, stop_now}, 8'h0);
    chk("R10 err", {6'b0, lim_err}, 8'h0);
    chk("R10 status", {6'b0, lim_status}, 8'h0);
    rst_n = 1'b1;
    tick(1);

    // Table: configurations and stop routing, R1 R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      logic [13:0] v;
      v = VEC[i];
      busy = 1'b0;
      err_clr = 2'b11;
      {pin_minus, pin_plus} = v[13:12];
      cfg_en = v[11:10];
      cfg_act_high = v[9];
      cfg_decel = v[8];
      cfg_swap = v[7];
      dir_minus = v[6];
      tick(1);
      err_clr = 2'b00;
      tick(3);
      chk("R1 R2 R3 status", {6'b0, lim_status}, {6'b0, v[5:4]});
      chk("R8 idle no stop", {6'b0, stop_decel, stop_now}, 8'h0);
      busy = 1'b1;
      tick(1);
      chk("R4 R5 R6 stop", {6'b0, stop_decel, stop_now}, {6'b0, v[3:2]});
      chk("R9 err", {6'b0, lim_err}, {6'b0, v[1:0]});
      busy = 1'b0;
      tick(1);
      chk("R7 strobe drop", {6'b0, stop_decel, stop_now}, 8'h0);
    end

    // R7: limit becomes active during a move, stop after three edges
    {pin_minus, pin_plus} = 2'b00;
    cfg_en = 2'b11; cfg_act_high = 1'b1; cfg_decel = 1'b1; cfg_swap = 1'b0;
    err_clr = 2'b11;
    tick(3);
    err_clr = 2'b00;
    busy = 1'b1; dir_minus = 1'b0;
    tick(2);
    pin_plus = 1'b1;
    tick(2);
    chk("R7 not yet", {6'b0, stop_decel, stop_now}, 8'h0);
    tick(1);
    chk("R7 in-move stop", {6'b0, stop_decel, stop_now}, 8'h2);
    tick(1);
    chk("R7 single strobe", {6'b0, stop_decel, stop_now}, 8'h0);
    tick(3);
    chk("R7 no repeat", {6'b0, stop_decel, stop_now}, 8'h0);

    // R9 sticky after release, per-bit clear
    busy = 1'b0;
    pin_plus = 1'b0;
    tick(4);
    chk("R9 sticky", {6'b0, lim_err}, 8'h1);
    err_clr = 2'b10;
    tick(1);
    chk("R9 other clear", {6'b0, lim_err}, 8'h1);
    err_clr = 2'b01;
    tick(1);
    chk("R9 cleared", {6'b0, lim_err}, 8'h0);
    err_clr = 2'b00;

    // R9 set wins over clear; R5 move away from active limit
    pin_plus = 1'b1;
    tick(3);
    busy = 1'b1; dir_minus = 1'b1;
    tick(2);
    chk("R5 away allowed", {6'b0, stop_decel, stop_now}, 8'h0);
    busy = 1'b0;
    tick(1);
    busy = 1'b1; dir_minus = 1'b0; err_clr = 2'b01;
    tick(1);
    chk("R9 set over clear", {6'b0, lim_err}, 8'h1);
    chk("R6 decel route", {6'b0, stop_decel, stop_now}, 8'h2);
    err_clr = 2'b00;
    busy = 1'b0;
    tick(1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule